// File: doc/BRIEF.md
# Dual Digital Phase Detector

This block measures the phase relation between a reference signal and a feedback signal with two detectors working side by side, both sampled by a fast system clock. The first detector combines one reference input with the feedback input through an exclusive-OR. Its output is a square wave whose duty cycle tracks the phase error. It sits at zero error when the two inputs are a quarter period apart, and its gain is 4 per cycle of phase error. The second detector is a set/reset flop driven by the falling edges of a second reference input and of the same feedback input. It sits at zero error when its inputs are half a period apart, and its gain is 2 per cycle of phase error.

Both outputs are meant to steer the count direction of a loop counter in a digital phase-locked loop. The three phase inputs are asynchronous to the system clock. Each one passes through a two-flop synchroniser. Edges are found by comparing each synchronised value with its value one cycle earlier. Both outputs are registered, so neither output glitches.

Top module: `dual_phase_cmp`

## Requirements
- R1: `xor_pd_o` is 1 when the synchronised `ref_xor_i` and `fb_i` differ, and 0 when they are equal.
- R2: A high-to-low transition on `fb_i` with no same-cycle fall on `ref_edge_i` sets `edge_pd_o` to 1.
- R3: A high-to-low transition on `ref_edge_i` with no same-cycle fall on `fb_i` clears `edge_pd_o` to 0.
- R4: Low-to-high transitions on `ref_edge_i` or `fb_i` leave `edge_pd_o` unchanged.
- R5: When falling edges on `ref_edge_i` and `fb_i` are detected in the same system cycle, `edge_pd_o` inverts.
- R6: While `rst` is high at a clock edge, both outputs become 0 at that edge.
- R7: An input change applied between two clock edges reaches either output at the third rising edge that follows.
- R8: For 16-cycle square waves with the reference lagging the feedback by d cycles, `xor_pd_o` is high for 2*min(d,16-d) cycles per period. At d=4 this is a 50% duty cycle. `edge_pd_o` is high for d cycles per period (d from 1 to 15). At d=8 this is a 50% duty cycle.
- R9: At the ends of the linear range the outputs no longer toggle. `xor_pd_o` stays low for in-phase inputs and stays high for inputs in antiphase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| ref_xor_i | input | 1 | Reference phase input for the exclusive-OR detector (asynchronous) |
| ref_edge_i | input | 1 | Reference phase input for the edge detector (asynchronous) |
| fb_i | input | 1 | Feedback phase input shared by both detectors (asynchronous) |
| xor_pd_o | output | 1 | Exclusive-OR detector output |
| edge_pd_o | output | 1 | Edge detector output: set by a feedback fall, cleared by a reference fall |

## Verification
The hardest case to reach from the ports is a falling edge on both edge-detector inputs within the same synchronised cycle, because the two fall edges normally arrive at different times. The bench drives both falls at the same falling clock edge so that they pass through the synchronisers together, and checks that the output inverts twice in a row. The phase sweep at zero offset then repeats this coincidence on every period. A sweep over all sixteen phase offsets compares the measured high time of each output with the expected arithmetic value, and this sweep covers both ends of the linear range.

// File: rtl/dual_phase_cmp.sv
module dual_phase_cmp (
  input  logic clk,
  input  logic rst,
  input  logic ref_xor_i,
  input  logic ref_edge_i,
  input  logic fb_i,
  output logic xor_pd_o,
  output logic edge_pd_o
);

  logic [1:0] ax_sync, ae_sync, fb_sync;
  logic       ae_last, fb_last;
  logic       ae_fall, fb_fall;

  assign ae_fall = ae_last & ~ae_sync[1];
  assign fb_fall = fb_last & ~fb_sync[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      ax_sync   <= '0;
      ae_sync   <= '0;
      fb_sync   <= '0;
      ae_last   <= 1'b0;
      fb_last   <= 1'b0;
      xor_pd_o  <= 1'b0;
      edge_pd_o <= 1'b0;
    end else begin
      ax_sync  <= {ax_sync[0], ref_xor_i};
      ae_sync  <= {ae_sync[0], ref_edge_i};
      fb_sync  <= {fb_sync[0], fb_i};
      ae_last  <= ae_sync[1];
      fb_last  <= fb_sync[1];
      xor_pd_o <= ax_sync[1] ^ fb_sync[1];
      case ({fb_fall, ae_fall})
        2'b10:   edge_pd_o <= 1'b1;
        2'b01:   edge_pd_o <= 1'b0;
        2'b11:   edge_pd_o <= ~edge_pd_o;
        default: edge_pd_o <= edge_pd_o;
      endcase
    end
  end

  logic [1:0] warm;
  always_ff @(posedge clk) begin
    if (rst)              warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  // R1
  xor_follow_chk: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> (xor_pd_o == ($past(ref_xor_i, 3) ^ $past(fb_i, 3))));

  // R2
  fb_fall_set_chk: assert property (@(posedge clk) disable iff (rst)
    (fb_fall && !ae_fall) |=> edge_pd_o);

  // R3
  ref_fall_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (ae_fall && !fb_fall) |=> !edge_pd_o);

  // R4
  no_fall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!ae_fall && !fb_fall) |=> $stable(edge_pd_o));

  // R5
  dual_fall_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    (ae_fall && fb_fall) |=> (edge_pd_o != $past(edge_pd_o)));

  // R6
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!xor_pd_o && !edge_pd_o));

endmodule

// File: tb/dual_phase_cmp_test.sv
`timescale 1ns/1ps
module dual_phase_cmp_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ref_xor_i = 1'b0;
  logic ref_edge_i = 1'b0;
  logic fb_i = 1'b0;
  logic xor_pd_o, edge_pd_o;

  int checks = 0;
  int fails = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  dual_phase_cmp uut (
    .clk(clk), .rst(rst), .ref_xor_i(ref_xor_i), .ref_edge_i(ref_edge_i),
    .fb_i(fb_i), .xor_pd_o(xor_pd_o), .edge_pd_o(edge_pd_o)
  );

  task automatic step();
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  initial begin
    logic s;
    int hx, he;
    repeat (3) step();
    // R6: outputs held low during reset
    chk("R6 xor in reset", xor_pd_o, 0);
    chk("R6 edge in reset", edge_pd_o, 0);
    rst = 1'b0;
    repeat (4) step();

    // R1 truth table
    for (int i = 0; i < 4; i++) begin
      ref_xor_i = i[1];
      fb_i = i[0];
      repeat (4) step();
      chk("R1 xor table", xor_pd_o, i[1] ^ i[0]);
    end

    // R7 latency of xor path
    ref_xor_i = 1'b0; fb_i = 1'b0;
    repeat (4) step();
    ref_xor_i = 1'b1;
    step(); step();
    chk("R7 xor before third edge", xor_pd_o, 0);
    step();
    chk("R7 xor at third edge", xor_pd_o, 1);

    // R2, R3, R7 on the edge path
    fb_i = 1'b1; ref_edge_i = 1'b1;
    repeat (4) step();
    s = edge_pd_o;
    fb_i = 1'b0;
    step(); step();
    chk("R7 edge before third edge", edge_pd_o, s);
    step();
    chk("R2 fb fall sets", edge_pd_o, 1);
    ref_edge_i = 1'b0;
    step(); step();
    chk("R7 edge hold before third edge", edge_pd_o, 1);
    step();
    chk("R3 ref fall clears", edge_pd_o, 0);

    // R4 rising edges ignored
    ref_edge_i = 1'b1;
    repeat (5) step();
    chk("R4 ref rise while low", edge_pd_o, 0);
    fb_i = 1'b1;
    repeat (5) step();
    chk("R4 fb rise while low", edge_pd_o, 0);
    fb_i = 1'b0;
    repeat (4) step();
    chk("R2 fb fall sets again", edge_pd_o, 1);
    fb_i = 1'b1;
    repeat (5) step();
    chk("R4 fb rise while high", edge_pd_o, 1);

    // R5 simultaneous falls
    ref_edge_i = 1'b1; fb_i = 1'b1;
    repeat (4) step();
    s = edge_pd_o;
    ref_edge_i = 1'b0; fb_i = 1'b0;
    repeat (3) step();
    chk("R5 dual fall toggles", edge_pd_o, !s);
    ref_edge_i = 1'b1; fb_i = 1'b1;
    repeat (4) step();
    ref_edge_i = 1'b0; fb_i = 1'b0;
    repeat (3) step();
    chk("R5 dual fall toggles back", edge_pd_o, s);

    // R8, R9, R5 phase sweep
    for (int d = 0; d < 16; d++) begin
      hx = 0; he = 0;
      for (int t = 0; t < 96; t++) begin
        fb_i = (t % 16) < 8;
        ref_xor_i = ((t + 16 - d) % 16) < 8;
        ref_edge_i = ref_xor_i;
        step();
        if (t >= 32) begin
          hx += xor_pd_o;
          he += edge_pd_o;
        end
      end
      if (d == 0 || d == 8)
        chk("R9 xor at range limit", hx, (d == 0) ? 0 : 64);
      else
        chk("R8 xor duty", hx, 8 * ((d < 8) ? d : 16 - d));
      if (d == 0)
        chk("R5 edge toggles every period", he, 32);
      else
        chk("R8 edge duty", he, 4 * d);
    end

    // R6 reset mid-run
    ref_edge_i = 1'b1; fb_i = 1'b1; ref_xor_i = 1'b0;
    repeat (4) step();
    fb_i = 1'b0; ref_xor_i = 1'b0;
    ref_xor_i = 1'b1;
    repeat (4) step();
    chk("R6 setup edge high", edge_pd_o, 1);
    chk("R6 setup xor high", xor_pd_o, 1);
    rst = 1'b1;
    step();
    chk("R6 reset clears xor", xor_pd_o, 0);
    chk("R6 reset clears edge", edge_pd_o, 0);
    rst = 1'b0;
    repeat (2) step();

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2000000;
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule